// File: doc/BRIEF.md
# Fixed-Priority Trap Selector

This block decides which pending trap a processor core takes next. It watches 32 interrupt lines and their enable mask, the global machine interrupt enable, a debug-mode flag, and two bus-fault events, one for loads and one for stores. Every clock it names a single winner, or none, and registers the result as a take strobe plus a numeric source ID.

The two bus faults are non-maskable. Each one sets a sticky pending flag inside the block. That flag stays set until the core acknowledges the fault while the fault is the presented winner. The store fault outranks the load fault, and both outrank every interrupt line. Among the interrupt lines the higher index wins, with one exception: line 7, the machine timer, always ranks last.

Trap entry, CSR updates, vectoring and pipeline control all live outside this block. The core only reads `take`/`take_id` and pulses `nmi_ack` when it starts a fault handler.

Top module: `trap_select`

## Requirements
- R1: A pending store-fault flag is presented as ID 1025 ahead of every other source.
- R2: A pending load-fault flag, with no store-fault flag pending, is presented as ID 1024 ahead of all interrupt lines, including line 31.
- R3: Among eligible interrupt lines other than line 7, the highest index wins, and line i is reported as ID i.
- R4: Line 7 (machine timer) is reported as ID 7 and is taken only when no other source is eligible.
- R5: An interrupt line is eligible only when its pending bit, its enable bit and `mie` are all 1.
- R6: The fault flags are presented regardless of `mie` and `irq_enable`.
- R7: While `debug_mode` is 1, `take` is 0. Fault flags stay pending and are presented once debug mode ends.
- R8: A fault flag is sticky. It clears only when `nmi_ack` is 1 at a clock edge where the registered output is `take`=1 with that fault's ID. A new fault event at that same edge keeps the flag set.
- R9: Outputs are registered. Interrupt inputs sampled at an edge appear on `take`/`take_id` after that edge. A fault pulse sampled at edge k sets its flag at k and reaches the outputs after edge k+1.
- R10: When no source is eligible, `take` is 0 and `take_id` keeps its previous value.
- R11: Synchronous reset drives `take` to 0, `take_id` to 0 and clears both fault flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pending | input | 32 | Pending interrupt lines, bit i is source i |
| irq_enable | input | 32 | Per-line enable mask |
| mie | input | 1 | Global machine interrupt enable |
| debug_mode | input | 1 | Core is in debug mode; suppresses all takes |
| load_fault | input | 1 | Load bus-fault event, sets the sticky load flag |
| store_fault | input | 1 | Store bus-fault event, sets the sticky store flag |
| nmi_ack | input | 1 | Acknowledge of the currently presented fault |
| take | output | 1 | Registered: a trap should be taken |
| take_id | output | 11 | Registered ID of the selected source |

## Verification
The directed cases cover these corner cases:
- **Timer alone, then timer with a lower line.** A plain highest-index encoder would pick line 7 over line 3.
- **Load fault together with line 31.** A design that ranks by line index would let line 31 win.
- **Acknowledge while the fault is not the presented winner, and acknowledge in debug mode.** A loose clear condition would drop a fault that was never serviced.
- **Fault event and acknowledge at the same edge.** Clear-wins logic would lose the new fault.

Randomized pending, enable, debug and fault patterns are then compared every cycle against a priority loop in the bench. This catches any swap in rank order, a lost mask term, or an ID that fails to hold when the block is idle.

// File: rtl/trap_sel_pkg.sv
package trap_sel_pkg;
  localparam int ID_W = 11;
  typedef logic [ID_W-1:0] trap_id_t;
  localparam trap_id_t LOAD_NMI_ID  = trap_id_t'(1024);
  localparam trap_id_t STORE_NMI_ID = trap_id_t'(1025);
  localparam int NMI_LOAD_IDX  = 0;
  localparam int NMI_STORE_IDX = 1;
  localparam int NMI_COUNT     = 2;
endpackage

// File: rtl/nmi_flags.sv
module nmi_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic         ack,
  input  logic [N-1:0] shown,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) pend[g] <= 1'b0;
      else     pend[g] <= set_evt[g] | (pend[g] & ~(ack & shown[g]));
    end

    // R8: a flag only drops through an acknowledge of its own presentation
    assert_nmi_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (pend[g] && !(ack && shown[g])) |=> pend[g]);
    assert_nmi_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (pend[g] && ack && shown[g] && !set_evt[g]) |=> !pend[g]);
  end
endmodule

// File: rtl/line_rank.sv
module line_rank #(
  parameter int NUM   = 32,
  parameter int TIMER = 7,
  parameter int IDW   = 11
) (
  input  logic [NUM-1:0] pending,
  input  logic [NUM-1:0] enable,
  input  logic           allow,
  output logic           hit,
  output logic [IDW-1:0] id
);
  logic [NUM-1:0] elig;
  logic [NUM-1:0] grant;

  assign elig = allow ? (pending & enable) : '0;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (i != TIMER && elig[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    if (!found && elig[TIMER]) grant[TIMER] = 1'b1;
  end

  always_comb begin
    id = '0;
    for (int i = 0; i < NUM; i++) begin
      if (grant[i]) id = id | IDW'(i);
    end
  end

  assign hit = |grant;

  // R3: resolution never grants more than one line
  always_comb begin
    assert_grant_single_R3: assert ($onehot0(grant));
  end
endmodule

// File: rtl/trap_select.sv
module trap_select
  import trap_sel_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int TIMER_LINE = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_pending,
  input  logic [NUM_LINES-1:0] irq_enable,
  input  logic                 mie,
  input  logic                 debug_mode,
  input  logic                 load_fault,
  input  logic                 store_fault,
  input  logic                 nmi_ack,
  output logic                 take,
  output logic [ID_W-1:0]      take_id
);
  localparam logic [NUM_LINES-1:0] TIMER_BIT = NUM_LINES'(1) << TIMER_LINE;

  logic [NMI_COUNT-1:0] nmi_pend;
  logic [NMI_COUNT-1:0] nmi_evt;
  logic [NMI_COUNT-1:0] nmi_shown;
  logic                 line_hit;
  trap_id_t             line_id;
  logic                 take_d;
  trap_id_t             id_d;

  assign nmi_evt[NMI_LOAD_IDX]    = load_fault;
  assign nmi_evt[NMI_STORE_IDX]   = store_fault;
  assign nmi_shown[NMI_LOAD_IDX]  = take && (take_id == LOAD_NMI_ID);
  assign nmi_shown[NMI_STORE_IDX] = take && (take_id == STORE_NMI_ID);

  nmi_flags #(.N(NMI_COUNT)) u_flags (
    .clk(clk), .rst(rst), .set_evt(nmi_evt), .ack(nmi_ack),
    .shown(nmi_shown), .pend(nmi_pend)
  );

  line_rank #(.NUM(NUM_LINES), .TIMER(TIMER_LINE), .IDW(ID_W)) u_rank (
    .pending(irq_pending), .enable(irq_enable), .allow(mie && !debug_mode),
    .hit(line_hit), .id(line_id)
  );

  always_comb begin
    take_d = 1'b0;
    id_d   = take_id;
    if (!debug_mode) begin
      if (nmi_pend[NMI_STORE_IDX]) begin
        take_d = 1'b1;
        id_d   = STORE_NMI_ID;
      end else if (nmi_pend[NMI_LOAD_IDX]) begin
        take_d = 1'b1;
        id_d   = LOAD_NMI_ID;
      end else if (line_hit) begin
        take_d = 1'b1;
        id_d   = line_id;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take    <= 1'b0;
      take_id <= '0;
    end else begin
      take    <= take_d;
      take_id <= id_d;
    end
  end

  assert_dbg_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    debug_mode |=> !take);
  assert_store_first_R1: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend[NMI_STORE_IDX] && !debug_mode) |=> (take && take_id == STORE_NMI_ID));
  assert_load_second_R2: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend[NMI_LOAD_IDX] && !nmi_pend[NMI_STORE_IDX] && !debug_mode)
      |=> (take && take_id == LOAD_NMI_ID));
  assert_timer_last_R4: assert property (@(posedge clk) disable iff (rst)
    (!debug_mode && mie && ((irq_pending & irq_enable & ~TIMER_BIT) != '0))
      |=> (take && take_id != trap_id_t'(TIMER_LINE)));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!debug_mode && nmi_pend == '0 && !line_hit) |=> (!take && $stable(take_id)));
endmodule

// File: tb/sim_trap_select.sv
`timescale 1ns/1ps
module sim_trap_select;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_pending = '0;
  logic [31:0] irq_enable  = '0;
  logic        mie = 1'b0, debug_mode = 1'b0;
  logic        load_fault = 1'b0, store_fault = 1'b0, nmi_ack = 1'b0;
  logic        take;
  logic [10:0] take_id;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  trap_select u0 (
    .clk(clk), .rst(rst), .irq_pending(irq_pending), .irq_enable(irq_enable),
    .mie(mie), .debug_mode(debug_mode), .load_fault(load_fault),
    .store_fault(store_fault), .nmi_ack(nmi_ack), .take(take), .take_id(take_id)
  );

  // Reference model built from the requirements
  logic        m_ld = 0, m_st = 0, m_take = 0;
  logic [10:0] m_id = 0;

  function automatic logic [11:0] ref_pick(input logic ld, input logic st,
      input logic [31:0] p, input logic [31:0] e, input logic ie, input logic dbg);
    if (dbg) return {1'b0, 11'd0};
    if (st)  return {1'b1, 11'd1025};
    if (ld)  return {1'b1, 11'd1024};
    if (ie) begin
      for (int i = 31; i >= 0; i--)
        if (i != 7 && p[i] && e[i]) return {1'b1, 11'(i)};
      if (p[7] && e[7]) return {1'b1, 11'd7};
    end
    return {1'b0, 11'd0};
  endfunction

  always @(posedge clk) begin
    logic [11:0] r;
    if (rst) begin
      m_ld <= 0; m_st <= 0; m_take <= 0; m_id <= 0;
    end else begin
      r = ref_pick(m_ld, m_st, irq_pending, irq_enable, mie, debug_mode);
      m_take <= r[11];
      if (r[11]) m_id <= r[10:0];
      m_ld <= load_fault  | (m_ld & ~(nmi_ack & m_take & (m_id == 11'd1024)));
      m_st <= store_fault | (m_st & ~(nmi_ack & m_take & (m_id == 11'd1025)));
    end
  end

  task automatic check(input string req, input logic et, input logic [10:0] eid);
    n_checks++;
    if (take !== et || take_id !== eid) begin
      n_fails++;
      $display("FAIL %s: take=%0b id=%0d expected take=%0b id=%0d", req, take, take_id, et, eid);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 reset state", 1'b0, 11'd0);

    irq_enable = '1; mie = 1; irq_pending = 32'h80;
    step(); check("R4 R9 timer alone", 1'b1, 11'd7);
    irq_pending = 32'h88;
    step(); check("R4 timer below line 3", 1'b1, 11'd3);
    mie = 0;
    step(); check("R5 R10 mie off", 1'b0, 11'd3);
    mie = 1; irq_pending = 32'h0010_0000; irq_enable = ~32'h0010_0000;
    step(); check("R5 masked line", 1'b0, 11'd3);
    irq_enable = '1; irq_pending = 32'h8000_0020;
    step(); check("R3 line 31 over 5", 1'b1, 11'd31);

    load_fault = 1;
    step(); check("R9 fault latency", 1'b1, 11'd31);
    load_fault = 0;
    step(); check("R2 load fault over line 31", 1'b1, 11'd1024);
    mie = 0; irq_enable = '0; store_fault = 1;
    step(); check("R9 store latency", 1'b1, 11'd1024);
    store_fault = 0;
    step(); check("R1 R6 store fault first", 1'b1, 11'd1025);
    nmi_ack = 1;
    step(); check("R8 ack edge", 1'b1, 11'd1025);
    nmi_ack = 0;
    step(); check("R8 store cleared load kept", 1'b1, 11'd1024);

    debug_mode = 1;
    step(); check("R7 debug quiet", 1'b0, 11'd1024);
    nmi_ack = 1;
    step(); check("R7 R8 ack in debug", 1'b0, 11'd1024);
    nmi_ack = 0; debug_mode = 0;
    step(); check("R7 fault after debug", 1'b1, 11'd1024);
    nmi_ack = 1;
    step(); check("R8 ack load", 1'b1, 11'd1024);
    nmi_ack = 0; irq_pending = '0;
    step(); check("R10 idle hold", 1'b0, 11'd1024);

    load_fault = 1;
    step(); check("R9 load set", 1'b0, 11'd1024);
    load_fault = 0;
    step(); check("R8 load pending", 1'b1, 11'd1024);
    load_fault = 1; nmi_ack = 1;
    step(); check("R8 set with ack", 1'b1, 11'd1024);
    load_fault = 0; nmi_ack = 0;
    step(); check("R8 set wins over ack", 1'b1, 11'd1024);
    nmi_ack = 1;
    step(); check("R8 final ack", 1'b1, 11'd1024);
    nmi_ack = 0;
    step(); check("R10 cleared idle", 1'b0, 11'd1024);

    void'($urandom(32'd2024));
    for (int k = 0; k < 4000; k++) begin
      irq_pending = $urandom() & $urandom();
      irq_enable  = $urandom() | $urandom();
      if ($urandom_range(3) == 0) irq_pending = irq_pending & 32'h80;
      mie         = ($urandom_range(3) != 0);
      debug_mode  = ($urandom_range(9) == 0);
      load_fault  = ($urandom_range(39) == 0);
      store_fault = ($urandom_range(49) == 0);
      nmi_ack     = ($urandom_range(4) == 0);
      step();
      check("R1-priority random vs model R3", m_take, m_id);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule